// File: doc/BRIEF.md
# Two-Wire Write-Only Control Register Slave

This block is a receive-only slave on a two-wire serial bus (SCL clock, SDA data). A system clock much faster than SCL oversamples both lines. The block recognises bus framing conditions and takes in one address byte and one data byte per transfer. It acknowledges each byte by pulling SDA low through an open-drain enable. The data byte is copied into a small control register only when the transfer closes with a STOP. A transfer that is cut short, aborted or addressed elsewhere leaves the register as it was.

The seven-bit slave address is fixed except for its lowest bit, which comes from an input pin. Two such slaves can therefore share a bus. The address is compared bit by bit as it arrives. On the first bit that disagrees, the slave goes quiet and disregards SCL until it sees a fresh START. After a STOP it is quiet in the same way.

The committed byte drives two output fields. The top bit is an operate/suspend flag. The lower seven bits are a level code. At reset the level code is 16, which is 1.3 V on a scale of 0.9 V plus 25 mV per step, and the flag is 0.

Top module: `twi_wr_slave`

## Requirements
- R1: While reset is held and after it is released, `level_o` is 16, `susp_o` is 0, `sda_oe_o` is 0 and `commit_o` is 0.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Bits clocked in without a preceding START are never acknowledged.
- R3: SDA is sampled on each SCL rising edge, and each byte is taken MSB first.
- R4: After the first byte, the slave acknowledges by holding SDA low through the whole ninth SCL clock. It does this only when bits 7..1 of that byte equal 0010100 with bit 1 replaced by `addr_sel_i` (0x28 when the pin is low, 0x2A when it is high) and bit 0 is 0.
- R5: If any address bit disagrees, the slave gives no acknowledge for the address or for any later byte, and the following STOP commits nothing.
- R6: If bit 0 (read/write) of the first byte is 1, the slave gives no acknowledge and commits nothing.
- R7: After a matching address, the data byte is acknowledged on its ninth clock. At STOP, `susp_o` takes data bit 7 and `level_o` takes data bits 6..0. Before that STOP the outputs keep their old value.
- R8: `commit_o` is high for exactly one clock per successful commit, and at no other time.
- R9: A STOP that arrives before a complete, acknowledged data byte leaves the outputs unchanged and gives no commit pulse.
- R10: A repeated START at any point restarts address reception and discards any data byte that has not yet been committed.
- R11: Between a STOP and the next START, SCL activity produces no acknowledge and no commit.
- R12: SDA is only ever pulled low, through `sda_oe_o`. The enable changes state only after an SCL falling edge, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_sel_i | input | 1 | Selects the lowest bit of the slave address |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| level_o | output | 7 | Committed level code |
| susp_o | output | 1 | Committed operate/suspend flag |
| commit_o | output | 1 | One-clock pulse when a new byte is committed |

## Verification
On every cycle, the assertions check four things. The acknowledge enable moves only after an SCL fall or a framing event. Each commit follows a detected STOP. The commit pulse never lasts longer than one clock. The register holds its value whenever no commit is flagged. The bench scenarios cover what a property cannot: the outcome of a whole transfer. They sweep every first byte under both pin settings and every data value. They also cover early drop-out on a bad address, refusal of reads, truncated transfers, repeated STARTs, SCL clocked with no START, and a falling SDA while SCL is low, none of which may count as framing.

// File: rtl/twi_wr_pkg.sv
package twi_wr_pkg;

    localparam int TWI_DATA_W = 8;
    localparam int TWI_LVL_W  = TWI_DATA_W - 1;
    localparam int TWI_ADDR_W = 7;
    localparam int TWI_CNT_W  = $clog2(TWI_DATA_W);

    // Events seen on the synchronized bus lines
    typedef struct packed {
        logic sda_s;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } twi_evt_t;

    // Committed control register: flag in the top bit, level below it
    typedef struct packed {
        logic                 susp;
        logic [TWI_LVL_W-1:0] level;
    } twi_ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_DATA,
        ST_DACK,
        ST_HOLD
    } twi_state_t;

    // Expected address bit at position idx, counted from the MSB
    function automatic logic addr_bit(input logic [TWI_ADDR_W-2:0] hi,
                                      input logic                  sel,
                                      input logic [TWI_CNT_W-1:0]  idx);
        logic [TWI_ADDR_W-1:0] full;
        full = {hi, sel} << idx;
        return full[TWI_ADDR_W-1];
    endfunction

    function automatic twi_ctrl_t to_ctrl(input logic [TWI_DATA_W-1:0] d);
        return twi_ctrl_t'(d);
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
    import twi_wr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output twi_evt_t evt
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_sh[LAST];
    assign sda_s = sda_sh[LAST];

    // Previous synchronized values for edge detection; idle bus is high
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.sda_s    = sda_s;
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/twi_frame_fsm.sv
module twi_frame_fsm
    import twi_wr_pkg::*;
#(
    parameter logic [TWI_ADDR_W-2:0] ADDR_HI = 6'b001010
) (
    input  logic                  clk,
    input  logic                  rst,
    input  twi_evt_t              evt,
    input  logic                  addr_sel,
    output logic                  sda_oe,
    output logic                  pend_valid,
    output logic [TWI_DATA_W-1:0] pend_data
);

    localparam logic [TWI_CNT_W-1:0] RW_IDX   = TWI_CNT_W'(TWI_ADDR_W);
    localparam logic [TWI_CNT_W-1:0] LAST_IDX = TWI_CNT_W'(TWI_DATA_W - 1);

    twi_state_t             state;
    logic [TWI_CNT_W-1:0]   cnt;
    logic [TWI_DATA_W-1:0]  shreg;
    logic                   byte_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            byte_done  <= 1'b0;
            sda_oe     <= 1'b0;
            pend_valid <= 1'b0;
            pend_data  <= '0;
        end else if (evt.start) begin
            // A START (first or repeated) restarts address reception
            state      <= ST_ADDR;
            cnt        <= '0;
            byte_done  <= 1'b0;
            sda_oe     <= 1'b0;
            pend_valid <= 1'b0;
        end else if (evt.stop) begin
            state      <= ST_IDLE;
            byte_done  <= 1'b0;
            sda_oe     <= 1'b0;
            pend_valid <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR: begin
                    if (evt.scl_rise) begin
                        if (cnt == RW_IDX) begin
                            if (evt.sda_s) begin
                                state <= ST_IDLE;   // read request: no ack
                            end else begin
                                byte_done <= 1'b1;
                            end
                        end else if (evt.sda_s != addr_bit(ADDR_HI, addr_sel, cnt)) begin
                            state <= ST_IDLE;       // early drop-out
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end else if (evt.scl_fall && byte_done) begin
                        state     <= ST_AACK;
                        sda_oe    <= 1'b1;
                        byte_done <= 1'b0;
                    end
                end
                ST_AACK: begin
                    if (evt.scl_fall) begin
                        state  <= ST_DATA;
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                    end
                end
                ST_DATA: begin
                    if (evt.scl_rise) begin
                        shreg <= {shreg[TWI_DATA_W-2:0], evt.sda_s};
                        if (cnt == LAST_IDX) begin
                            byte_done <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end else if (evt.scl_fall && byte_done) begin
                        state     <= ST_DACK;
                        sda_oe    <= 1'b1;
                        byte_done <= 1'b0;
                    end
                end
                ST_DACK: begin
                    if (evt.scl_fall) begin
                        state      <= ST_HOLD;
                        sda_oe     <= 1'b0;
                        pend_valid <= 1'b1;
                        pend_data  <= shreg;
                    end
                end
                ST_HOLD: begin
                    // further bytes are not acknowledged; wait for STOP
                end
                default: begin
                    // idle: SCL is disregarded until START
                end
            endcase
        end
    end

    // R12
    oe_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> $past(evt.scl_fall || evt.start || evt.stop));

endmodule

// File: rtl/twi_commit_reg.sv
module twi_commit_reg
    import twi_wr_pkg::*;
#(
    parameter logic [TWI_LVL_W-1:0] LEVEL_RST = 7'd16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  stop_evt,
    input  logic                  pend_valid,
    input  logic [TWI_DATA_W-1:0] pend_data,
    output twi_ctrl_t             ctrl,
    output logic                  commit
);

    localparam twi_ctrl_t CTRL_RST = '{susp: 1'b0, level: LEVEL_RST};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= CTRL_RST;
            commit <= 1'b0;
        end else begin
            commit <= stop_evt & pend_valid;
            if (stop_evt && pend_valid) begin
                ctrl <= to_ctrl(pend_data);
            end
        end
    end

    // R8
    commit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    // R7
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |-> $stable(ctrl));

endmodule

// File: rtl/twi_wr_slave.sv
module twi_wr_slave
    import twi_wr_pkg::*;
#(
    parameter logic [TWI_ADDR_W-2:0] ADDR_HI     = 6'b001010,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [TWI_LVL_W-1:0]  LEVEL_RST   = 7'd16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic                 addr_sel_i,
    output logic                 sda_oe_o,
    output logic [TWI_LVL_W-1:0] level_o,
    output logic                 susp_o,
    output logic                 commit_o
);

    twi_evt_t              evt;
    logic                  stop_evt;
    logic                  pend_valid;
    logic [TWI_DATA_W-1:0] pend_data;
    twi_ctrl_t             ctrl;

    twi_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    twi_frame_fsm #(
        .ADDR_HI (ADDR_HI)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .addr_sel   (addr_sel_i),
        .sda_oe     (sda_oe_o),
        .pend_valid (pend_valid),
        .pend_data  (pend_data)
    );

    assign stop_evt = evt.stop;

    twi_commit_reg #(
        .LEVEL_RST (LEVEL_RST)
    ) u_reg (
        .clk        (clk),
        .rst        (rst),
        .stop_evt   (stop_evt),
        .pend_valid (pend_valid),
        .pend_data  (pend_data),
        .ctrl       (ctrl),
        .commit     (commit_o)
    );

    assign level_o = ctrl.level;
    assign susp_o  = ctrl.susp;

    // R8
    commit_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> $past(stop_evt));

endmodule

// File: tb/tb_twi_wr_slave.sv
module tb_twi_wr_slave;

    localparam int H = 4;   // system clocks per SCL half period

    logic       clk = 1'b0;
    logic       rst;
    logic       scl_m;
    logic       sda_m;
    logic       addr_sel;
    logic       sda_oe;
    logic [6:0] level;
    logic       susp;
    logic       commit;
    logic       sda_bus;

    int vectors = 0;
    int miscmp  = 0;
    int commit_cnt = 0;
    int oe_cnt = 0;
    int width_err = 0;
    logic commit_prev = 1'b0;
    logic done = 1'b0;

    logic [6:0] exp_lvl = 7'd16;
    logic       exp_susp = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    twi_wr_slave dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .addr_sel_i (addr_sel),
        .sda_oe_o   (sda_oe),
        .level_o    (level),
        .susp_o     (susp),
        .commit_o   (commit)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (commit) commit_cnt++;
            if (commit && commit_prev) width_err++;
            commit_prev = commit;
            if (sda_oe) oe_cnt++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscmp++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clk_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_tx(input logic b);
        clk_n(1); sda_m = b;
        clk_n(H - 1); scl_m = 1'b1;
        clk_n(H); scl_m = 1'b0;
    endtask

    task automatic ack_rx(output logic a);
        clk_n(1); sda_m = 1'b1;
        clk_n(H - 1); scl_m = 1'b1;
        clk_n(H - 1); a = ~sda_bus;
        clk_n(1); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int nbits, output logic a);
        for (int i = 0; i < nbits; i++) bit_tx(b[7 - i]);
        if (nbits == 8) ack_rx(a);
        else a = 1'b0;
    endtask

    task automatic do_start();
        clk_n(1); sda_m = 1'b1;
        clk_n(H); scl_m = 1'b1;
        clk_n(H); sda_m = 1'b0;
        clk_n(H); scl_m = 1'b0;
    endtask

    task automatic do_stop();
        clk_n(1); sda_m = 1'b0;
        clk_n(H); scl_m = 1'b1;
        clk_n(H); sda_m = 1'b1;
        clk_n(H + 4);
    endtask

    task automatic check_reg(input string tag);
        chk(tag, int'(level), int'(exp_lvl));
        chk(tag, int'(susp), int'(exp_susp));
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            miscmp++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

    initial begin
        logic a1, a2, match;
        logic [7:0] fb, d, good;
        int c0, o0;

        rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; addr_sel = 1'b0;
        clk_n(4);
        // R1: values while reset is held
        chk("R1 level in reset", int'(level), 16);
        chk("R1 oe in reset", int'(sda_oe), 0);
        rst = 1'b0;
        clk_n(3);
        chk("R1 level", int'(level), 16);
        chk("R1 susp", int'(susp), 0);
        chk("R1 oe", int'(sda_oe), 0);
        chk("R1 commit", int'(commit), 0);

        // R3/R4/R5/R6: every first byte under both pin settings
        for (int sel = 0; sel < 2; sel++) begin
            addr_sel = sel[0];
            for (int f = 0; f < 256; f++) begin
                fb = f[7:0];
                d  = fb ^ 8'hA5;
                match = (fb[7:1] == {6'b001010, sel[0]}) && !fb[0];
                c0 = commit_cnt; o0 = oe_cnt;
                do_start();
                send_byte(fb, 8, a1);
                send_byte(d, 8, a2);
                do_stop();
                if (fb[7:1] == {6'b001010, sel[0]} && fb[0])
                    chk("R6 read refused", int'(a1), 0);
                else
                    chk("R3/R4/R5 address ack", int'(a1), int'(match));
                chk("R5/R7 data ack", int'(a2), int'(match));
                chk("R8 commit count", commit_cnt - c0, int'(match));
                chk("R12 oe used only for acks", int'(oe_cnt != o0), int'(match));
                if (match) begin
                    exp_lvl = d[6:0]; exp_susp = d[7];
                end
                check_reg("R7 register after stop");
            end
        end

        // R7: every data value, committed only at STOP
        addr_sel = 1'b1;
        good = 8'h2A;
        for (int v = 0; v < 256; v++) begin
            d = v[7:0];
            c0 = commit_cnt;
            do_start();
            send_byte(good, 8, a1);
            send_byte(d, 8, a2);
            clk_n(2 * H);
            chk("R7 unchanged before stop", int'({susp, level}), int'({exp_susp, exp_lvl}));
            do_stop();
            exp_lvl = d[6:0]; exp_susp = d[7];
            chk("R7 data ack", int'(a2), 1);
            check_reg("R7 committed value");
            chk("R8 one pulse", commit_cnt - c0, 1);
        end

        // R9: truncated data byte, and address only
        c0 = commit_cnt;
        do_start(); send_byte(good, 8, a1); send_byte(8'h7E, 4, a2); do_stop();
        do_start(); send_byte(good, 8, a1); do_stop();
        chk("R9 no commit", commit_cnt - c0, 0);
        check_reg("R9 register unchanged");

        // R10: repeated START inside the address, then a full write
        c0 = commit_cnt;
        do_start(); send_byte(good, 3, a1);
        do_start(); send_byte(good, 8, a1); send_byte(8'h3C, 8, a2); do_stop();
        exp_lvl = 7'h3C; exp_susp = 1'b0;
        chk("R10 restart address ack", int'(a1), 1);
        chk("R10 one commit", commit_cnt - c0, 1);
        check_reg("R10 value after restart");

        // R10: first data discarded, second committed
        c0 = commit_cnt;
        do_start(); send_byte(good, 8, a1); send_byte(8'h81, 8, a2);
        do_start(); send_byte(good, 8, a1); send_byte(8'h22, 8, a2); do_stop();
        exp_lvl = 7'h22; exp_susp = 1'b0;
        chk("R10 only latest commits", commit_cnt - c0, 1);
        check_reg("R10 latest value");

        // R10: data then repeated START then STOP commits nothing
        c0 = commit_cnt;
        do_start(); send_byte(good, 8, a1); send_byte(8'hC4, 8, a2);
        do_start(); do_stop();
        chk("R10 discarded data", commit_cnt - c0, 0);
        check_reg("R10 register kept");

        // R11: SCL toggling after STOP with no START
        c0 = commit_cnt; o0 = oe_cnt;
        clk_n(1); scl_m = 1'b0;
        send_byte(good, 8, a1);
        send_byte(8'h55, 8, a2);
        clk_n(1); sda_m = 1'b1;
        clk_n(H); scl_m = 1'b1;
        clk_n(2 * H);
        chk("R11 no ack", int'(a1 | a2), 0);
        chk("R11 no oe", oe_cnt - o0, 0);
        chk("R11 no commit", commit_cnt - c0, 0);

        // R2: SDA falls while SCL is low, which is not a START
        c0 = commit_cnt;
        clk_n(1); scl_m = 1'b0;
        clk_n(H); sda_m = 1'b0;
        clk_n(H); scl_m = 1'b1;
        clk_n(H); scl_m = 1'b0;
        send_byte(good, 8, a1);
        send_byte(8'h11, 8, a2);
        do_stop();
        chk("R2 no ack without START", int'(a1), 0);
        chk("R2 no commit", commit_cnt - c0, 0);
        check_reg("R2 register kept");

        chk("R8 pulse width", width_err, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule